// File: doc/BRIEF.md
# Peripheral E-Clock and Valid-Memory-Address Sequencer

This block lets a bus master run the slow synchronous handshake that older eight-bit peripherals expect. A free-running divide-by-ten counter on the processor clock produces a peripheral clock, E. E is low for six clocks and high for four. When a peripheral signals a valid peripheral address during an active data strobe, the block waits for the next E period to begin. It then asserts valid-memory-address and stays in step with E.

On the last counter state of that period, with E high and one clock before E falls, the block raises an end-of-cycle request. The acknowledge logic uses this request to close the bus cycle, so the transfer completes on the falling edge of E. Both valid-memory-address and the end-of-cycle request stay asserted until the data strobe is withdrawn, and they clear on the next clock edge after that.

Top module: `peripheral_eclock_seq`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, E is low and both memValidN and endReqN are high (negated). The divider restarts from state 0.
- R2: E repeats every 10 clocks. Counting divider states 0 to 9 from reset, E is low in states 0 to 5 and high in states 6 to 9. The pattern continues with or without bus activity.
- R3: memValidN goes low only on the clock edge that moves the divider from state 9 to state 0, the first E-low clock of a period. It does so only once the peripheral request has been seen while dataStrobeN is low. It never asserts in the middle of a period.
- R4: While dataStrobeN is low and periphAddrN stays high, memValidN and endReqN stay high.
- R5: endReqN goes low in divider state 9, the last E-high clock before E falls, of the period whose first state had memValidN low.
- R6: Once low, memValidN and endReqN stay low while dataStrobeN stays low. Both return high on the first clock edge after dataStrobeN goes high.
- R7: A peripheral request (periphAddrN low) while dataStrobeN is high has no effect: it does not assert memValidN in a later strobe that has no request.
- R8: A peripheral request of a single clock during an active strobe is remembered, so memValidN still asserts at the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock that E is derived from |
| rstN | input | 1 | Asynchronous reset, active low |
| dataStrobeN | input | 1 | Delayed data strobe of the current bus cycle, active low |
| periphAddrN | input | 1 | Valid peripheral address request from the peripheral, active low |
| eClk | output | 1 | Peripheral clock, one tenth of clk, low 6 and high 4 |
| memValidN | output | 1 | Valid memory address to the peripheral, active low |
| endReqN | output | 1 | End-of-cycle request to the acknowledge logic, active low |

## Verification
A wrong divider state shows on eClk within one period of 10 clocks, as a run of lows or highs of the wrong length. It also moves memValidN and endReqN away from their fixed positions in the period. A broken request latch or clear path shows at the ports as memValidN asserting one period late, mid-period, or not at all, or as a sticky memValidN or endReqN one clock after the strobe is withdrawn. The bench compares all three outputs against an independent cycle model on every clock. Directed and random bus cycles place the request at every phase of E.

// File: rtl/esync_pkg.sv
package esync_pkg;
  // Timing strobes the divider hands to the sequencer
  typedef struct packed {
    logic periodEnd;  // last state of the E period (E high, about to fall)
    logic termSlot;   // state in which termination is armed
  } divStrobes_t;
endpackage

// File: rtl/esync_divider.sv
module esync_divider
  import esync_pkg::*;
#(
  parameter int DIV     = 10,
  parameter int LOW_CNT = 6
) (
  input  logic        clk,
  input  logic        rstN,
  output logic        eOut,
  output divStrobes_t strobes
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST     = CW'(DIV - 1);
  localparam logic [CW-1:0] TERM     = CW'(DIV - 2);
  localparam logic [CW-1:0] HIGH_BEG = CW'(LOW_CNT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_comb begin
    eOut              = (cnt >= HIGH_BEG);
    strobes.periodEnd = (cnt == LAST);
    strobes.termSlot  = (cnt == TERM);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);  // R2
  AST_E_FALLS_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eOut) |-> (cnt == '0));  // R2
  AST_E_RISES_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eOut) |-> (cnt == HIGH_BEG));  // R2
endmodule

// File: rtl/esync_seq.sv
module esync_seq
  import esync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeAct,
  input  logic        vpaAct,
  input  divStrobes_t strobes,
  output logic        vmaQ,
  output logic        termQ
);
  logic vpaSeen;
  logic reqPending;

  assign reqPending = vpaSeen || vpaAct;

  // Request latch: held for the life of the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           vpaSeen <= 1'b0;
    else if (!strobeAct) vpaSeen <= 1'b0;
    else if (vpaAct)     vpaSeen <= 1'b1;
  end

  // Valid memory address: only entered at a new E period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   vmaQ <= 1'b0;
    else if (!strobeAct)                         vmaQ <= 1'b0;
    else if (strobes.periodEnd && reqPending)    vmaQ <= 1'b1;
  end

  // Registered termination armed in the decode state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   termQ <= 1'b0;
    else if (!strobeAct)                         termQ <= 1'b0;
    else if (strobes.termSlot && vmaQ)           termQ <= 1'b1;
  end

  AST_VMA_AT_PERIOD_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vmaQ) |-> $past(strobes.periodEnd));  // R3
  AST_NO_VMA_WITHOUT_VPA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vmaQ) |-> $past(reqPending));  // R4
  AST_TERM_AT_LAST_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(termQ) |-> strobes.periodEnd);  // R5
  AST_TERM_NEEDS_VMA: assert property (@(posedge clk) disable iff (!rstN)
    termQ |-> vmaQ);  // R5
  AST_CLEAR_ON_STROBE_END: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strobeAct) |-> (!vmaQ && !termQ));  // R6
endmodule

// File: rtl/peripheral_eclock_seq.sv
module peripheral_eclock_seq
  import esync_pkg::*;
#(
  parameter int DIV     = 10,
  parameter int LOW_CNT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataStrobeN,
  input  logic periphAddrN,
  output logic eClk,
  output logic memValidN,
  output logic endReqN
);
  divStrobes_t strobes;
  logic vmaQ;
  logic termQ;

  esync_divider #(.DIV(DIV), .LOW_CNT(LOW_CNT)) i_divider (
    .clk     (clk),
    .rstN    (rstN),
    .eOut    (eClk),
    .strobes (strobes)
  );

  esync_seq i_seq (
    .clk       (clk),
    .rstN      (rstN),
    .strobeAct (!dataStrobeN),
    .vpaAct    (!periphAddrN),
    .strobes   (strobes),
    .vmaQ      (vmaQ),
    .termQ     (termQ)
  );

  assign memValidN = !vmaQ;
  assign endReqN   = !termQ;
endmodule

// File: tb/test_peripheral_eclock_seq.sv
module test_peripheral_eclock_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataStrobeN = 1'b1;
  logic periphAddrN = 1'b1;
  logic eClk, memValidN, endReqN;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit compareOn = 1'b0;

  // Independent reference state
  int  mCnt = 0;
  bit  mSeen = 0, mVma = 0, mTerm = 0;

  peripheral_eclock_seq i_peripheral_eclock_seq (
    .clk(clk), .rstN(rstN), .dataStrobeN(dataStrobeN),
    .periphAddrN(periphAddrN), .eClk(eClk),
    .memValidN(memValidN), .endReqN(endReqN)
  );

  always #5 clk = ~clk;

  function automatic bit expE(int c);
    return (c >= 6);  // R2: low in states 0..5, high in 6..9
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mSeen <= 0; mVma <= 0; mTerm <= 0;
    end else begin
      bit sA, vA;
      sA = !dataStrobeN; vA = !periphAddrN;
      mCnt  <= (mCnt == 9) ? 0 : mCnt + 1;
      mSeen <= sA && (mSeen || vA);
      mVma  <= sA && (mVma || (mCnt == 9 && (mSeen || vA)));
      mTerm <= sA && (mTerm || (mVma && mCnt == 8));
    end
  end

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (compareOn) begin
      check("R2 eClk", eClk, expE(mCnt));
      check("R3 memValidN", memValidN, !mVma);
      check("R5 endReqN", endReqN, !mTerm);
    end
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Full bus cycle with VPA; checks R5 position and R6 clear
  task automatic busCycle(int preDly, int vpaLen, int holdExtra);
    int guard = 0;
    @(negedge clk);
    dataStrobeN = 1'b0;
    repeat (preDly) @(negedge clk);
    periphAddrN = 1'b0;
    repeat (vpaLen) @(negedge clk);
    periphAddrN = (vpaLen == 1) ? 1'b1 : 1'b0;
    while (endReqN && guard < 40) begin @(negedge clk); guard++; end
    check("R5 term reached", endReqN, 0);
    check("R5 term in state 9", mCnt, 9);
    check("R5 eClk high at term", eClk, 1);
    repeat (holdExtra) begin
      @(negedge clk);
      check("R6 hold vma", memValidN, 0);
      check("R6 hold term", endReqN, 0);
    end
    dataStrobeN = 1'b1; periphAddrN = 1'b1;
    @(negedge clk);
    check("R6 vma cleared", memValidN, 1);
    check("R6 term cleared", endReqN, 1);
  endtask

  initial begin
    bit sawVma;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 eClk in reset", eClk, 0);
    check("R1 memValidN in reset", memValidN, 1);
    check("R1 endReqN in reset", endReqN, 1);
    #2 rstN = 1'b1;
    @(negedge clk);
    compareOn = 1'b1;
    check("R1 after release state", mCnt, 1);

    // R2: free-running pattern
    idle(25);

    // R4: strobe without request
    sawVma = 0;
    dataStrobeN = 1'b0;
    repeat (30) begin @(negedge clk); if (!memValidN || !endReqN) sawVma = 1; end
    check("R4 no vma without vpa", sawVma, 0);
    dataStrobeN = 1'b1;
    idle(2);

    // R7: request outside strobe ignored
    periphAddrN = 1'b0;
    idle(12);
    periphAddrN = 1'b1;
    @(negedge clk);
    dataStrobeN = 1'b0;
    sawVma = 0;
    repeat (15) begin @(negedge clk); if (!memValidN) sawVma = 1; end
    check("R7 stale vpa ignored", sawVma, 0);
    dataStrobeN = 1'b1;
    idle(3);

    // R8: single-clock request remembered
    busCycle(0, 1, 0);
    check("R8 pulse latched (cycle completed)", nFails == 0, 1);
    // R3 corner: request at each phase
    for (int p = 0; p < 10; p++) busCycle(p, 2, p % 3);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      int kind = $urandom_range(0, 3);
      if (kind == 0) begin
        dataStrobeN = 1'b0;
        idle($urandom_range(1, 25));
        dataStrobeN = 1'b1;
        idle($urandom_range(1, 4));
      end else begin
        busCycle($urandom_range(0, 12), $urandom_range(1, 5), $urandom_range(0, 3));
        idle($urandom_range(0, 7));
      end
    end
    idle(5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule